// File: doc/BRIEF.md
# Two-Pass Decimal Digit Adder

This block adds two single decimal digits held in binary-coded form (codes 0000 to 1001 are legal, 1010 to 1111 never are). It owns exactly one 4-bit binary adder and runs it up to twice per addition. The first pass adds the two operands and latches the 4-bit sum into the low result digit. When that sum is not a legal decimal digit, or the adder produced a carry, a second pass feeds the latched low digit and the constant six back through the same adder, replaces the low digit with the corrected value and sets the high digit to one.

A small controller sequences the passes. It waits in an idle state for a one-cycle start pulse, runs the compute pass, optionally the correction pass, then parks in a hold state with `done` high and the result frozen. A start pulse seen in hold launches the next addition directly. The operands only need to be valid on the cycle after start is sampled.

Top module: `bcd_digit_adder`

## Requirements
- R1: While reset is active and on the first cycle after it, `done` is 0, `sum_lo` is 0000 and `sum_hi` is 0000.
- R2: In the idle state with `start` low, the block stays idle: `done` stays 0 and both result digits keep their values.
- R3: When the operands sum to 9 or less, `done` rises on the second cycle after the cycle in which `start` is sampled high, with `sum_lo` equal to the decimal sum and `sum_hi` equal to 0000.
- R4: When the operands sum to 10..15 (no binary carry), a correction pass is added: `done` rises on the third cycle after `start`, with `sum_lo` = sum − 10 and `sum_hi` = 0001.
- R5: When the binary add of the operands carries out (sums 16..18, e.g. 9+9 gives 0010 with carry), the correction pass is also taken, giving `sum_lo` = sum − 10 and `sum_hi` = 0001 (9+9 gives 1000 and 0001).
- R6: `sum_hi` is only ever 0000 or 0001.
- R7: While `done` is high and `start` is low, `done`, `sum_lo` and `sum_hi` hold their values.
- R8: A `start` pulse while `done` is high begins a new addition: `done` is 0 on the next cycle and the new result follows the timing of R3/R4.
- R9: For every one of the 100 legal operand pairs, `sum_hi`·10 + `sum_lo` equals the decimal sum once `done` is high, and `sum_lo` is then at most 1001.
- R10: The operands are read only in the compute pass; changing them during the correction pass or in hold does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an addition |
| op_a | input | 4 | First decimal digit operand |
| op_b | input | 4 | Second decimal digit operand |
| sum_lo | output | 4 | Low decimal digit of the result |
| sum_hi | output | 4 | High decimal digit of the result (0000 or 0001) |
| done | output | 1 | Result valid, block waiting in hold |

## Verification
The assertions take for granted that both operands are legal decimal digits on the compute cycle; with an illegal code the first-pass sum can exceed what one correction repairs, and the check that the low digit stays at or below 1001 would fire. The stimulus only ever drives codes 0000 to 1001, holds the operands steady from the start pulse through the compute cycle, and drives `start` for exactly one cycle. The operand-change test swaps in other legal digits only, so the legality assumption still holds while proving that the correction pass ignores the ports.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

  localparam int DIGIT_W   = 4;
  localparam int MAX_DIGIT = 9;
  localparam int FIX_CONST = 6;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADD  = 2'd1,
    ST_FIX  = 2'd2,
    ST_HOLD = 2'd3
  } ctrl_state_t;

  // A first-pass result needs the add-six correction when it is not a legal
  // decimal digit or when the binary add overflowed the digit width.
  function automatic logic needs_fix(input digit_t sum, input logic carry);
    return carry || (sum > digit_t'(MAX_DIGIT));
  endfunction

  function automatic digit_t fix_operand();
    return digit_t'(FIX_CONST);
  endfunction

endpackage

// File: rtl/bcd_add_binadd.sv
module bcd_add_binadd #(
  parameter int W = 4
) (
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  output logic [W-1:0] sum,
  output logic         carry
);

  logic [W:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = in_x[i] ^ in_y[i] ^ chain[i];
    assign chain[i+1] = (in_x[i] & in_y[i]) | (chain[i] & (in_x[i] ^ in_y[i]));
  end

  assign carry = chain[W];

endmodule

// File: rtl/bcd_add_ctrl.sv
module bcd_add_ctrl
  import bcd_add_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fix_need,
  output logic sel_fix,
  output logic load_lo,
  output logic hi_clr,
  output logic hi_set,
  output logic add_pass,
  output logic fix_pass,
  output logic in_hold
);

  ctrl_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_ADD;
      ST_ADD:  state_d = fix_need ? ST_FIX : ST_HOLD;
      ST_FIX:  state_d = ST_HOLD;
      ST_HOLD: if (start) state_d = ST_ADD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign add_pass = (state_q == ST_ADD);
  assign fix_pass = (state_q == ST_FIX);
  assign in_hold  = (state_q == ST_HOLD);

  assign sel_fix = fix_pass;
  assign load_lo = add_pass | fix_pass;
  assign hi_clr  = add_pass | (state_q == ST_IDLE);
  assign hi_set  = fix_pass;

  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE)); // R2

  AST_FIX_AFTER_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    fix_pass |-> ($past(state_q) == ST_ADD)); // R4

  AST_HOLD_FROM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_hold) |-> ($past(state_q) == ST_ADD || $past(state_q) == ST_FIX)); // R3

endmodule

// File: rtl/bcd_add_dpath.sv
module bcd_add_dpath
  import bcd_add_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  digit_t op_a,
  input  digit_t op_b,
  input  logic   sel_fix,
  input  logic   load_lo,
  input  logic   hi_clr,
  input  logic   hi_set,
  output logic   fix_need,
  output logic   add_carry,
  output digit_t lo_q,
  output digit_t hi_q
);

  digit_t x_src, y_src, add_sum;

  assign x_src = sel_fix ? lo_q : op_a;
  assign y_src = sel_fix ? fix_operand() : op_b;

  bcd_add_binadd #(.W(DIGIT_W)) u_adder (
    .in_x  (x_src),
    .in_y  (y_src),
    .sum   (add_sum),
    .carry (add_carry)
  );

  assign fix_need = needs_fix(add_sum, add_carry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_q <= '0;
    else if (load_lo) lo_q <= add_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (hi_set) hi_q <= digit_t'(1);
    else if (hi_clr) hi_q <= '0;
  end

  AST_HI_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q == digit_t'(0)) || (hi_q == digit_t'(1))); // R6

  AST_FIX_SETS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    hi_set |=> (hi_q == digit_t'(1))); // R4

endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_add_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] op_a,
  input  logic [3:0] op_b,
  output logic [3:0] sum_lo,
  output logic [3:0] sum_hi,
  output logic       done
);

  logic sel_fix, load_lo, hi_clr, hi_set;
  logic add_pass, fix_pass, in_hold;
  logic fix_need, add_carry;
  digit_t lo_q, hi_q;

  bcd_add_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fix_need (fix_need),
    .sel_fix  (sel_fix),
    .load_lo  (load_lo),
    .hi_clr   (hi_clr),
    .hi_set   (hi_set),
    .add_pass (add_pass),
    .fix_pass (fix_pass),
    .in_hold  (in_hold)
  );

  bcd_add_dpath u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .sel_fix   (sel_fix),
    .load_lo   (load_lo),
    .hi_clr    (hi_clr),
    .hi_set    (hi_set),
    .fix_need  (fix_need),
    .add_carry (add_carry),
    .lo_q      (lo_q),
    .hi_q      (hi_q)
  );

  assign sum_lo = lo_q;
  assign sum_hi = hi_q;
  assign done   = in_hold;

  AST_SMALL_SUM_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (add_pass && !fix_need) |=> (done && sum_hi == 4'd0)); // R3

  AST_CARRY_CORRECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (add_pass && add_carry) |=> fix_pass); // R5

  AST_LO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sum_lo <= 4'd9)); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(sum_lo) && $stable(sum_hi))); // R7

  AST_START_LEAVES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done); // R8

endmodule

// File: tb/bcd_digit_adder_tb_top.sv
module bcd_digit_adder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op_a = '0;
  logic [3:0] op_b = '0;
  logic [3:0] sum_lo, sum_hi;
  logic       done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_digit_adder dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .sum_lo (sum_lo),
    .sum_hi (sum_hi),
    .done   (done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Launch one addition and return the number of cycles until done, with
  // operands optionally swapped to other digits once the compute pass is over.
  task automatic launch(input int a, input int b, input bit scramble, output int lat);
    @(negedge clk);
    op_a  = 4'(a);
    op_b  = 4'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (n == 1 && scramble) begin
        op_a = 4'((a + 3) % 10);
        op_b = 4'((b + 7) % 10);
      end
      if (done) begin
        lat = n + 1;
        break;
      end
    end
  endtask

  function automatic int want_lat(input int a, input int b);
    return (a + b >= 10) ? 3 : 2;
  endfunction

  task automatic t_reset();
    check("R1", "done after reset", int'(done), 0);
    check("R1", "sum_lo after reset", int'(sum_lo), 0);
    check("R1", "sum_hi after reset", int'(sum_hi), 0);
  endtask

  task automatic t_idle_wait();
    for (int n = 0; n < 5; n++) @(negedge clk);
    check("R2", "done while idle", int'(done), 0);
    check("R2", "sum_lo while idle", int'(sum_lo), 0);
    check("R2", "sum_hi while idle", int'(sum_hi), 0);
  endtask

  task automatic t_small_sum();
    int lat;
    launch(5, 3, 1'b0, lat);
    check("R3", "latency 5+3", lat, 2);
    check("R3", "sum_lo 5+3", int'(sum_lo), 8);
    check("R3", "sum_hi 5+3", int'(sum_hi), 0);
    launch(9, 0, 1'b0, lat);
    check("R3", "latency 9+0", lat, 2);
    check("R3", "sum_lo 9+0", int'(sum_lo), 9);
  endtask

  task automatic t_corrected();
    int lat;
    launch(9, 3, 1'b0, lat);
    check("R4", "latency 9+3", lat, 3);
    check("R4", "sum_lo 9+3", int'(sum_lo), 2);
    check("R4", "sum_hi 9+3", int'(sum_hi), 1);
    launch(5, 5, 1'b0, lat);
    check("R4", "sum_lo 5+5", int'(sum_lo), 0);
    check("R4", "sum_hi 5+5", int'(sum_hi), 1);
  endtask

  task automatic t_carry();
    int lat;
    launch(9, 9, 1'b0, lat);
    check("R5", "latency 9+9", lat, 3);
    check("R5", "sum_lo 9+9", int'(sum_lo), 8);
    check("R5", "sum_hi 9+9", int'(sum_hi), 1);
    launch(8, 8, 1'b0, lat);
    check("R5", "sum_lo 8+8", int'(sum_lo), 6);
    check("R6", "sum_hi 8+8", int'(sum_hi), 1);
  endtask

  task automatic t_hold_and_restart();
    int lat;
    logic [3:0] lo0, hi0;
    launch(7, 6, 1'b0, lat);
    lo0 = sum_lo;
    hi0 = sum_hi;
    op_a = 4'd1;
    op_b = 4'd2;
    for (int n = 0; n < 4; n++) @(negedge clk);
    check("R7", "done held", int'(done), 1);
    check("R7", "sum_lo held", int'(sum_lo), int'(lo0));
    check("R7", "sum_hi held", int'(sum_hi), int'(hi0));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8", "done drops after restart", int'(done), 0);
    @(negedge clk);
    check("R8", "done after restart 1+2", int'(done), 1);
    check("R8", "sum_lo after restart 1+2", int'(sum_lo), 3);
    check("R8", "sum_hi after restart 1+2", int'(sum_hi), 0);
  endtask

  task automatic t_operand_change();
    int lat;
    launch(9, 4, 1'b1, lat);
    check("R10", "latency with late operand change", lat, 3);
    check("R10", "sum_lo 9+4 after operand change", int'(sum_lo), 3);
    check("R10", "sum_hi 9+4 after operand change", int'(sum_hi), 1);
    launch(2, 3, 1'b1, lat);
    check("R10", "sum_lo 2+3 after operand change", int'(sum_lo), 5);
  endtask

  task automatic t_sweep();
    int lat;
    int bad = 0;
    for (int a = 0; a < 10; a++) begin
      for (int b = 0; b < 10; b++) begin
        launch(a, b, 1'b0, lat);
        if (lat != want_lat(a, b) || (int'(sum_hi) * 10 + int'(sum_lo)) != a + b
            || sum_hi > 4'd1) begin
          bad++;
          $display("FAIL R9 pair %0d+%0d actual=%0d%0d lat=%0d expected=%0d lat=%0d",
                   a, b, sum_hi, sum_lo, lat, a + b, want_lat(a, b));
        end
      end
    end
    checks++;
    if (bad != 0) failures++;
  endtask

  initial begin
    rst_n = 1'b0;
    #(CLK_PERIOD * 3 + 1);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_wait();
    t_small_sum();
    t_corrected();
    t_carry();
    t_hold_and_restart();
    t_operand_change();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule